// File: doc/BRIEF.md
# Register State Transfer Engine

When execution moves between the wide out-of-order engine and the narrow in-order engine, the architectural register values have to follow it. Caches, translation buffers and the branch predictor are shared by both engines, so this block moves only the register contents, which is well under a kilobyte. It walks the architectural registers 0 through 31 in ascending order, one per cycle, through a three-stage pipeline. Stage 1 reads the rename table. Stage 2 reads the source register. Stage 3 writes the destination register file.

The direction is captured with the start request.
- Big-to-little: the rename table gives the physical register (one of 128, a 7-bit index) that holds architectural register i. That physical register is read, and its value is written into little-engine register i.
- Little-to-big: the rename table gives the physical register currently mapped to i. Little-engine register i is read, and its value is written into that physical register.

The outgoing engine may still be retiring instructions while the walk runs. Each retiring write reports its architectural index on a commit input. If that register has already entered stage 1, the copy may be stale. The register is then marked dirty and copied again once the sweep finishes. A done pulse closes the transfer once nothing is dirty and the pipeline is empty.

Top module: `reg_xfer_engine`

## Requirements
- R1: After reset, busy_o, done_o, dst_we_o, rt_re_o and src_re_o are all low.
- R2: When idle, start_i is accepted at a rising edge and busy_o goes high. dir_i is captured at that edge: 0 means big-to-little and 1 means little-to-big. dst_we_o is only ever high while busy_o is high.
- R3: Big-to-little. For every architectural register i, including register 0, a write is issued with dst_idx_o equal to i (upper two bits zero). Its data is the value of physical register rt[i], read with src_idx_o = rt[i].
- R4: Little-to-big. For every architectural register i, a write is issued with dst_idx_o equal to rt[i]. Its data is the value of little-engine register i, read with src_idx_o = i (upper two bits zero).
- R5: One register enters the pipeline per cycle, in ascending order from 0. The first write is on dst_*_o during the cycle that begins 2 rising edges after the edge that accepted start_i, and the sweep writes follow in consecutive cycles.
- R6: Without re-issue, done_o is high for exactly one cycle, beginning 34 rising edges after the accepting edge. That is the cycle after the last write. busy_o is low from the next edge on.
- R7: A commit_valid_i pulse whose commit_idx_i names a register that has already entered stage 1, or is entering it in that same cycle, causes one extra write of that register after the sweep. The extra write carries the updated value, and it delays done_o by one cycle.
- R8: A commit naming a register that has not yet entered stage 1 causes no extra write. The later copy still carries the updated value.
- R9: start_i while busy is ignored. It does not restart the walk, change the direction, or shift the write count or the done timing.
- R10: commit_valid_i while idle has no effect: no write, no busy, no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transfer request |
| dir_i | input | 1 | Direction at start: 0 big-to-little, 1 little-to-big |
| commit_valid_i | input | 1 | Outgoing engine retired a register write |
| commit_idx_i | input | 5 | Architectural index of that write |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rt_re_o | output | 1 | Rename-table read enable |
| rt_idx_o | output | 5 | Rename-table architectural index |
| rt_phys_i | input | 7 | Physical index returned in the same cycle |
| src_re_o | output | 1 | Source register read enable |
| src_idx_o | output | 7 | Source register index |
| src_data_i | input | 32 | Source register data, same cycle |
| dst_we_o | output | 1 | Destination write enable |
| dst_idx_o | output | 7 | Destination register index |
| dst_data_o | output | 32 | Destination write data |

## Verification
A corrupted sweep pointer shows within one cycle as an out-of-order or missing destination index in the write stream. A lost dirty bit shows at done time as a stale destination value and a write count one short. A spurious dirty bit adds a write and delays done_o by a cycle. The bench therefore checks the exact cycle of the first write and of done_o, the write count, and the full destination contents after every transfer. In each transfer with a commit, the commit cycle and index are placed so that the bench knows beforehand whether a re-issue must happen.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic {
    DIR_B2L = 1'b0,
    DIR_L2B = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/xfer_sched.sv
module xfer_sched
  import xfer_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  localparam int ARCH_W  = $clog2(NUM_ARCH),
  localparam int PTR_W   = ARCH_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic              commit_valid_i,
  input  logic [ARCH_W-1:0] commit_idx_i,
  input  logic              pipe_busy_i,
  output logic              busy_o,
  output xfer_dir_e         dir_o,
  output logic              issue_v_o,
  output logic [ARCH_W-1:0] issue_idx_o,
  output logic              done_o
);

  logic                busy_q;
  xfer_dir_e           dir_q;
  logic [PTR_W-1:0]    ptr_q;
  logic [NUM_ARCH-1:0] issued_q, dirty_q;

  logic              sweep_done, fix_any, commit_hit;
  logic [ARCH_W-1:0] fix_idx;

  assign sweep_done = (ptr_q == PTR_W'(NUM_ARCH));
  assign fix_any    = |dirty_q;

  // lowest dirty register first
  always_comb begin
    fix_idx = '0;
    for (int i = NUM_ARCH - 1; i >= 0; i--) begin
      if (dirty_q[i]) fix_idx = ARCH_W'(i);
    end
  end

  assign issue_v_o   = busy_q && (!sweep_done || fix_any);
  assign issue_idx_o = sweep_done ? fix_idx : ptr_q[ARCH_W-1:0];

  assign commit_hit = busy_q && commit_valid_i &&
                      (issued_q[commit_idx_i] || (issue_v_o && issue_idx_o == commit_idx_i));

  assign done_o = busy_q && sweep_done && !fix_any && !pipe_busy_i && !commit_hit;
  assign busy_o = busy_q;
  assign dir_o  = dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      dir_q    <= DIR_B2L;
      ptr_q    <= '0;
      issued_q <= '0;
      dirty_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q   <= 1'b1;
        dir_q    <= xfer_dir_e'(dir_i);
        ptr_q    <= '0;
        issued_q <= '0;
        dirty_q  <= '0;
      end
    end else begin
      if (done_o) busy_q <= 1'b0;
      if (issue_v_o) begin
        issued_q[issue_idx_o] <= 1'b1;
        if (!sweep_done) ptr_q <= ptr_q + 1'b1;
        else             dirty_q[fix_idx] <= 1'b0;
      end
      if (commit_hit) dirty_q[commit_idx_i] <= 1'b1;  // set wins over clear
    end
  end

  AST_PTR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PTR_W'(NUM_ARCH)); // R5
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i |=> $stable(dir_q)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_q); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && !start_i |=> $stable(dirty_q) && $stable(issued_q) && !busy_q); // R10

endmodule

// File: rtl/xfer_pipe.sv
module xfer_pipe
  import xfer_pkg::*;
#(
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  xfer_dir_e         dir_i,
  input  logic              issue_v_i,
  input  logic [ARCH_W-1:0] issue_idx_i,
  output logic              rt_re_o,
  output logic [ARCH_W-1:0] rt_idx_o,
  input  logic [PHYS_W-1:0] rt_phys_i,
  output logic              src_re_o,
  output logic [PHYS_W-1:0] src_idx_o,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              dst_we_o,
  output logic [PHYS_W-1:0] dst_idx_o,
  output logic [DATA_W-1:0] dst_data_o,
  output logic              busy_o
);

  logic              s1_v_q, s2_v_q;
  logic [ARCH_W-1:0] s1_arch_q;
  logic [PHYS_W-1:0] s1_phys_q, s2_idx_q, arch_ext;
  logic [DATA_W-1:0] s2_data_q;

  generate
    if (PHYS_W > ARCH_W) begin : g_zext
      assign arch_ext = {{(PHYS_W - ARCH_W){1'b0}}, s1_arch_q};
    end else begin : g_same
      assign arch_ext = PHYS_W'(s1_arch_q);
    end
  endgenerate

  // stage 1: rename lookup
  assign rt_re_o  = issue_v_i;
  assign rt_idx_o = issue_idx_i;

  // stage 2: source read; identity side depends on direction
  assign src_re_o  = s1_v_q;
  assign src_idx_o = (dir_i == DIR_L2B) ? arch_ext : s1_phys_q;

  // stage 3: destination write
  assign dst_we_o   = s2_v_q;
  assign dst_idx_o  = s2_idx_q;
  assign dst_data_o = s2_data_q;
  assign busy_o     = s1_v_q | s2_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_q    <= 1'b0;
      s1_arch_q <= '0;
      s1_phys_q <= '0;
      s2_v_q    <= 1'b0;
      s2_idx_q  <= '0;
      s2_data_q <= '0;
    end else begin
      s1_v_q <= issue_v_i;
      if (issue_v_i) begin
        s1_arch_q <= issue_idx_i;
        s1_phys_q <= rt_phys_i;
      end
      s2_v_q <= s1_v_q;
      if (s1_v_q) begin
        s2_idx_q  <= (dir_i == DIR_L2B) ? s1_phys_q : arch_ext;
        s2_data_q <= src_data_i;
      end
    end
  end

  AST_PIPE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_v_q |=> dst_we_o); // R5
  AST_READ_FOLLOWS_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_re_o |=> src_re_o); // R5

endmodule

// File: rtl/reg_xfer_engine.sv
module reg_xfer_engine
  import xfer_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 128,
  parameter int DATA_W   = 32,
  localparam int ARCH_W  = $clog2(NUM_ARCH),
  localparam int PHYS_W  = $clog2(NUM_PHYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic              commit_valid_i,
  input  logic [ARCH_W-1:0] commit_idx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rt_re_o,
  output logic [ARCH_W-1:0] rt_idx_o,
  input  logic [PHYS_W-1:0] rt_phys_i,
  output logic              src_re_o,
  output logic [PHYS_W-1:0] src_idx_o,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              dst_we_o,
  output logic [PHYS_W-1:0] dst_idx_o,
  output logic [DATA_W-1:0] dst_data_o
);

  xfer_dir_e         dir;
  logic              issue_v, pipe_busy;
  logic [ARCH_W-1:0] issue_idx;

  xfer_sched #(.NUM_ARCH(NUM_ARCH)) u_sched (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .dir_i          (dir_i),
    .commit_valid_i (commit_valid_i),
    .commit_idx_i   (commit_idx_i),
    .pipe_busy_i    (pipe_busy),
    .busy_o         (busy_o),
    .dir_o          (dir),
    .issue_v_o      (issue_v),
    .issue_idx_o    (issue_idx),
    .done_o         (done_o)
  );

  xfer_pipe #(.ARCH_W(ARCH_W), .PHYS_W(PHYS_W), .DATA_W(DATA_W)) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dir_i       (dir),
    .issue_v_i   (issue_v),
    .issue_idx_i (issue_idx),
    .rt_re_o     (rt_re_o),
    .rt_idx_o    (rt_idx_o),
    .rt_phys_i   (rt_phys_i),
    .src_re_o    (src_re_o),
    .src_idx_o   (src_idx_o),
    .src_data_i  (src_data_i),
    .dst_we_o    (dst_we_o),
    .dst_idx_o   (dst_idx_o),
    .dst_data_o  (dst_data_o),
    .busy_o      (pipe_busy)
  );

  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_we_o |-> busy_o); // R2
  AST_DONE_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !dst_we_o && !rt_re_o); // R6
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o); // R2

endmodule

// File: tb/reg_xfer_engine_tb.sv
module reg_xfer_engine_tb;
  localparam int NA = 32;
  localparam int NP = 128;
  localparam int DW = 32;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, dir_i = 1'b0, commit_valid_i = 1'b0;
  logic [4:0] commit_idx_i = '0;
  logic busy_o, done_o, rt_re_o, src_re_o, dst_we_o;
  logic [4:0] rt_idx_o;
  logic [6:0] rt_phys_i, src_idx_o, dst_idx_o;
  logic [DW-1:0] src_data_i, dst_data_o;

  logic [6:0]    rt [NA];
  logic [DW-1:0] pf [NP];
  logic [DW-1:0] la [NA];
  logic [DW-1:0] dst_big [NP];
  logic [DW-1:0] dst_lit [NA];
  logic dir_r = 1'b0;

  int n_vec = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  assign rt_phys_i  = rt[rt_idx_o];
  assign src_data_i = dir_r ? la[src_idx_o[4:0]] : pf[src_idx_o];

  reg_xfer_engine u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .dir_i(dir_i),
    .commit_valid_i(commit_valid_i), .commit_idx_i(commit_idx_i),
    .busy_o(busy_o), .done_o(done_o), .rt_re_o(rt_re_o), .rt_idx_o(rt_idx_o),
    .rt_phys_i(rt_phys_i), .src_re_o(src_re_o), .src_idx_o(src_idx_o),
    .src_data_i(src_data_i), .dst_we_o(dst_we_o), .dst_idx_o(dst_idx_o),
    .dst_data_o(dst_data_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input bit d);
    int mul, off;
    mul = int'($urandom % 64) * 2 + 1;
    off = int'($urandom % 128);
    for (int i = 0; i < NA; i++) rt[i] = 7'((i * mul + off) % 128);
    for (int i = 0; i < NP; i++) begin pf[i] = $urandom | 1; dst_big[i] = '0; end
    for (int i = 0; i < NA; i++) begin la[i] = $urandom | 1; dst_lit[i] = '0; end
    dir_r = d;
  endtask

  function automatic int exp_extra(input int ck, input int cj);
    return (ck > 0 && cj < ck) ? 1 : 0;   // index already entered stage 1
  endfunction

  // ck/cj: commit at negedge ck with index cj (ck=0: none); sk: extra start at negedge sk
  task automatic run_xfer(input bit d, input int ck, input int cj, input int sk);
    int done_k, nw, first_w, ex;
    bit seq_ok;
    string tag;
    fill(d);
    done_k = 0; nw = 0; first_w = 0; seq_ok = 1;
    ex = exp_extra(ck, cj);
    start_i = 1'b1; dir_i = d;
    for (int k = 1; k <= 200; k++) begin
      @(negedge clk);
      if (dst_we_o) begin
        if (nw == 0) first_w = k;
        if (nw < NA) begin
          if (d) seq_ok &= (dst_idx_o == rt[nw]);
          else   seq_ok &= (dst_idx_o == 7'(nw));
        end
        if (d) dst_big[dst_idx_o] = dst_data_o;
        else   dst_lit[dst_idx_o[4:0]] = dst_data_o;
        nw++;
      end
      if (done_o) begin done_k = k; break; end
      start_i = (k == sk);
      dir_i   = (k == sk) ? ~d : d;
      commit_valid_i = 1'b0;
      if (k == ck) begin
        commit_valid_i = 1'b1;
        commit_idx_i   = 5'(cj);
        if (d) la[cj] = $urandom | 1;
        else   pf[rt[cj]] = $urandom | 1;
      end
    end
    start_i = 1'b0; commit_valid_i = 1'b0;
    tag = (ck > 0) ? ((ex != 0) ? "R7" : "R8") : "R6";
    if (done_k == 0) begin
      n_vec++; n_bad++;
      $display("FAIL R6 watchdog: done never seen (actual 0 expected %0d)", 35 + ex);
    end
    chk(done_k == 35 + ex, tag, "done cycle", done_k, 35 + ex);
    chk(nw == NA + ex, tag, "write count", nw, NA + ex);
    chk(first_w == 3, "R5", "first write cycle", first_w, 3);
    chk(seq_ok, "R5", "ascending write order", seq_ok, 1);
    if (sk > 0) chk(done_k == 35 + ex && nw == NA + ex, "R9", "start while busy", nw, NA + ex);
    for (int i = 0; i < NA; i++) begin
      if (d) chk(dst_big[rt[i]] == la[i], "R4", $sformatf("reg %0d", i), dst_big[rt[i]], la[i]);
      else   chk(dst_lit[i] == pf[rt[i]], "R3", $sformatf("reg %0d", i), dst_lit[i], pf[rt[i]]);
    end
    @(negedge clk);
    chk(!done_o && !busy_o, "R6", "done single pulse, idle after", {done_o, busy_o}, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int ck, cj;
    void'($urandom(32'd4242));
    fill(1'b0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !dst_we_o && !rt_re_o && !src_re_o, "R1", "reset outputs",
        {busy_o, done_o, dst_we_o, rt_re_o, src_re_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    run_xfer(1'b0, 0, 0, 0);          // R3 plain, includes register 0
    run_xfer(1'b1, 0, 0, 0);          // R4 plain
    run_xfer(1'b0, 10, 5, 0);         // R7 already copied
    run_xfer(1'b1, 13, 12, 0);        // R7 register entering stage 1 that cycle
    run_xfer(1'b0, 10, 20, 0);        // R8 not yet reached
    run_xfer(1'b1, 8, 8, 0);          // R8 boundary: enters next cycle
    run_xfer(1'b0, 1, 0, 0);          // R7 register 0 during its own lookup
    run_xfer(1'b0, 0, 0, 12);         // R9 start while busy
    run_xfer(1'b1, 20, 3, 5);         // R9 with a re-issue

    // R10 commit while idle
    begin
      int w;
      w = 0;
      @(negedge clk);
      commit_valid_i = 1'b1; commit_idx_i = 5'd7;
      @(negedge clk);
      commit_valid_i = 1'b0;
      repeat (5) begin
        @(negedge clk);
        if (dst_we_o || busy_o || done_o) w++;
      end
      chk(w == 0, "R10", "idle commit activity", w, 0);
    end

    for (int t = 0; t < 24; t++) begin
      ck = (t % 3 == 0) ? 0 : int'($urandom % 31) + 1;
      cj = int'($urandom % 32);
      run_xfer(1'($urandom), ck, cj, 0);   // R3 R4 R7 R8 random
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule